// File: doc/BRIEF.md
# Configurable Audio Frame Serializer

This block is the transmit side of a serial audio port running as frame master. On every cycle of the bit clock it works out where it is in the current audio frame. From that position it drives a frame-sync line and one serial data bit. Software sets these values: how many bit clocks the frame holds, how wide and how early the sync pulse is, its polarity, the word size, the bit order, how many slots the frame carries, and whether unused bit positions are driven low or left floating.

Audio words arrive on a valid/ready port. The block asks for one word at the first bit of every declared slot. If no word is offered, the slot goes out as silence and a sticky underrun flag is raised. The settings are captured once per frame, so a frame in flight never changes shape.

Top module: `aud_frame_tx`

## Requirements
- R1: `cfg_size` selects the word size and the slot width: 0→8, 1→10, 2→16, 3→20, 4→24, and 5, 6, 7→32 bits. A word is right-justified in `s_data`. Bits above the word size are never sent. With `cfg_lsb_first`=0, word bit W-1 goes out first and bit 0 goes out last.
- R2: With `cfg_lsb_first`=1, word bit 0 goes out first and bit W-1 goes out last.
- R3: A frame lasts `cfg_frame_len`+1 bit clocks (1 to 256). Positions 0 to L-1 repeat back to back while the block is enabled.
- R4: With `cfg_fs_early`=0, FS is active at frame positions 0 to A-1, where A = `cfg_fs_width`+1 (1 to 128).
- R5: With `cfg_fs_early`=1, FS is active at the positions p for which (p+1) mod L < A. The pulse therefore begins on the last bit of the preceding frame. That last bit follows the settings of the frame it belongs to.
- R6: With `cfg_fs_low`=0, FS is high when active. With `cfg_fs_low`=1, FS is low when active. While the block is idle, FS rests at the inactive level set by the live `cfg_fs_low` input.
- R7: Slot k, for k < S = `cfg_slots`+1, occupies positions k·W to k·W+W-1. Slots go out in increasing order. A slot that runs past the frame end is cut off there.
- R8: At positions outside every slot, `cfg_pad_hiz`=0 gives `sd_oe`=1 and `sd_o`=0. `cfg_pad_hiz`=1 gives `sd_oe`=0 and `sd_o`=0.
- R9: `s_ready` is high only in the cycle of a slot's first bit. The word is taken if `s_valid` is high then. Otherwise the slot sends zeros and `underrun` goes high at the next rising edge. It stays high until `cfg_en` is seen low.
- R10: All configuration inputs are sampled at the rising edge that starts a frame. Changes in the middle of a frame take effect only from the next frame.
- R11: `rst`, which is synchronous and active high, or `cfg_en` low at a rising edge, makes the block idle from that edge. While idle, `sd_oe`=0, `sd_o`=0, FS is inactive and `underrun`=0. When `cfg_en` is seen high while idle, the cycle after that edge is position 0 of a new frame.
- R12: `sd_o`, `sd_oe` and `fs_o` change only on the falling edge of `clk`. The values for a position appear at the falling edge inside that position's cycle, so a receiver can sample them on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Run enable |
| cfg_frame_len | input | 8 | Frame length minus one |
| cfg_fs_width | input | 7 | FS active length minus one |
| cfg_fs_early | input | 1 | FS starts one bit before slot 0 |
| cfg_fs_low | input | 1 | FS active-low |
| cfg_size | input | 3 | Word size code |
| cfg_lsb_first | input | 1 | Send LSB first |
| cfg_slots | input | 4 | Slot count minus one |
| cfg_pad_hiz | input | 1 | Float data line outside slots |
| s_valid | input | 1 | Word offered |
| s_data | input | 32 | Word, right-justified |
| s_ready | output | 1 | Word taken this cycle if valid |
| sd_o | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data drive enable |
| fs_o | output | 1 | Frame sync |
| underrun | output | 1 | Sticky missing-word flag |

## Verification
The tricky cycle is the last bit of a frame. When the early sync option is set, the FS pulse for the next frame starts on that bit, and the same edge reloads the settings for the frame that follows. The bench provokes this by changing the length, offset, polarity and word size in the middle of a frame. A cycle-accurate model then judges FS, data and drive on every bit, using the old settings up to the boundary and the new ones after it. A second overlap is a slot start that coincides with a frame wrap. A one-bit frame and a 16-slot, 32-bit frame truncated at 256 bits both exercise it.

// File: rtl/aud_frame_tx_pkg.sv
package aud_frame_tx_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 8;
    localparam int ACT_W  = 7;
    localparam int SLOT_W = 4;
    localparam int SBIT_W = $clog2(WORD_W) + 1;

    // Settings captured once per frame
    typedef struct packed {
        logic [LEN_W-1:0]  frame_len_m1;
        logic [ACT_W-1:0]  fs_act_m1;
        logic              fs_early;
        logic              fs_low;
        logic [2:0]        size_code;
        logic              lsb_first;
        logic [SLOT_W-1:0] slots_m1;
        logic              pad_hiz;
    } frame_cfg_t;

    // Where the current bit clock sits inside the frame
    typedef struct packed {
        logic [LEN_W-1:0]  bit_pos;
        logic [SLOT_W:0]   slot_idx;
        logic [SBIT_W-1:0] slot_bit;
    } frame_pos_t;

    // Values launched onto the pins
    typedef struct packed {
        logic data;
        logic drive;
        logic sync;
    } line_out_t;

    function automatic logic [SBIT_W-1:0] word_bits(input logic [2:0] code);
        case (code)
            3'd0:    word_bits = SBIT_W'(8);
            3'd1:    word_bits = SBIT_W'(10);
            3'd2:    word_bits = SBIT_W'(16);
            3'd3:    word_bits = SBIT_W'(20);
            3'd4:    word_bits = SBIT_W'(24);
            default: word_bits = SBIT_W'(WORD_W);
        endcase
    endfunction

endpackage

// File: rtl/aud_frame_ctr.sv
module aud_frame_ctr
    import aud_frame_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  frame_cfg_t        cfg_in,
    output logic              run,
    output frame_cfg_t        cfg_q,
    output frame_pos_t        pos,
    output logic [SBIT_W-1:0] width,
    output logic              in_slot,
    output logic              slot_start
);

    logic last_bit;

    assign width      = word_bits(cfg_q.size_code);
    assign last_bit   = run && (pos.bit_pos == cfg_q.frame_len_m1);
    assign in_slot    = run && (pos.slot_idx <= {1'b0, cfg_q.slots_m1});
    assign slot_start = in_slot && (pos.slot_bit == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            cfg_q <= '0;
            pos   <= '0;
        end else if (!en) begin
            run <= 1'b0;
            pos <= '0;
        end else if (!run || last_bit) begin
            run   <= 1'b1;
            cfg_q <= cfg_in;
            pos   <= '0;
        end else begin
            pos.bit_pos <= pos.bit_pos + 1'b1;
            if (pos.slot_bit == width - 1'b1) begin
                pos.slot_bit <= '0;
                if (in_slot) begin
                    pos.slot_idx <= pos.slot_idx + 1'b1;
                end
            end else begin
                pos.slot_bit <= pos.slot_bit + 1'b1;
            end
        end
    end

    AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        run |-> pos.bit_pos <= cfg_q.frame_len_m1); // R3

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en && last_bit) |=> (run && pos.bit_pos == '0 && pos.slot_idx == '0)); // R3

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (run && !last_bit) |=> $stable(cfg_q)); // R10

    AST_SLOT_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> pos.slot_bit < width); // R7

endmodule

// File: rtl/aud_fs_shaper.sv
module aud_fs_shaper
    import aud_frame_tx_pkg::*;
(
    input  logic             run,
    input  logic [LEN_W-1:0] bit_pos,
    input  logic [LEN_W-1:0] frame_len_m1,
    input  logic [ACT_W-1:0] fs_act_m1,
    input  logic             fs_early,
    input  logic             fs_low,
    input  logic             idle_low,
    output logic             sync
);

    logic [LEN_W-1:0] look;
    logic             active;

    always_comb begin
        // Early mode looks one position ahead, folding the last bit onto 0
        if (fs_early && (bit_pos == frame_len_m1)) begin
            look = '0;
        end else if (fs_early) begin
            look = bit_pos + 1'b1;
        end else begin
            look = bit_pos;
        end
        active = (look <= LEN_W'(fs_act_m1));
        sync   = run ? (active ^ fs_low) : idle_low;
    end

endmodule

// File: rtl/aud_word_shifter.sv
module aud_word_shifter
    import aud_frame_tx_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              run,
    input  logic              in_slot,
    input  logic              slot_start,
    input  logic              lsb_first,
    input  logic [SBIT_W-1:0] width,
    input  logic              s_valid,
    input  logic [DW-1:0]     s_data,
    output logic              s_ready,
    output logic              bit_out,
    output logic              underrun
);

    logic [DW-1:0] word;
    logic [DW-1:0] aligned;
    logic [DW-1:0] sh_q;

    assign s_ready = slot_start;
    assign word    = (slot_start && s_valid) ? s_data : '0;
    assign aligned = word << (SBIT_W'(DW) - width);

    always_comb begin
        if (!in_slot) begin
            bit_out = 1'b0;
        end else if (slot_start) begin
            bit_out = lsb_first ? word[0] : aligned[DW-1];
        end else begin
            bit_out = lsb_first ? sh_q[0] : sh_q[DW-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (slot_start) begin
            sh_q <= lsb_first ? (word >> 1) : (aligned << 1);
        end else if (run) begin
            sh_q <= lsb_first ? (sh_q >> 1) : (sh_q << 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            underrun <= 1'b0;
        end else if (slot_start && !s_valid) begin
            underrun <= 1'b1;
        end
    end

    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (en && slot_start && !s_valid) |=> underrun); // R9

    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && underrun) |=> underrun); // R9

endmodule

// File: rtl/aud_frame_tx.sv
module aud_frame_tx
    import aud_frame_tx_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic [LEN_W-1:0]  cfg_frame_len,
    input  logic [ACT_W-1:0]  cfg_fs_width,
    input  logic              cfg_fs_early,
    input  logic              cfg_fs_low,
    input  logic [2:0]        cfg_size,
    input  logic              cfg_lsb_first,
    input  logic [SLOT_W-1:0] cfg_slots,
    input  logic              cfg_pad_hiz,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic              sd_o,
    output logic              sd_oe,
    output logic              fs_o,
    output logic              underrun
);

    frame_cfg_t        cfg_live;
    frame_cfg_t        cfg_q;
    frame_pos_t        pos;
    logic              run;
    logic              in_slot;
    logic              slot_start;
    logic [SBIT_W-1:0] width;
    logic              bit_out;
    logic              sync;
    line_out_t         line_nxt;
    line_out_t         line_q;

    assign cfg_live = '{frame_len_m1: cfg_frame_len, fs_act_m1: cfg_fs_width,
                        fs_early: cfg_fs_early, fs_low: cfg_fs_low,
                        size_code: cfg_size, lsb_first: cfg_lsb_first,
                        slots_m1: cfg_slots, pad_hiz: cfg_pad_hiz};

    aud_frame_ctr u_ctr (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_en),
        .cfg_in     (cfg_live),
        .run        (run),
        .cfg_q      (cfg_q),
        .pos        (pos),
        .width      (width),
        .in_slot    (in_slot),
        .slot_start (slot_start)
    );

    aud_fs_shaper u_fs (
        .run          (run),
        .bit_pos      (pos.bit_pos),
        .frame_len_m1 (cfg_q.frame_len_m1),
        .fs_act_m1    (cfg_q.fs_act_m1),
        .fs_early     (cfg_q.fs_early),
        .fs_low       (cfg_q.fs_low),
        .idle_low     (cfg_fs_low),
        .sync         (sync)
    );

    aud_word_shifter #(.DW(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_en),
        .run        (run),
        .in_slot    (in_slot),
        .slot_start (slot_start),
        .lsb_first  (cfg_q.lsb_first),
        .width      (width),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .s_ready    (s_ready),
        .bit_out    (bit_out),
        .underrun   (underrun)
    );

    assign line_nxt = '{data:  bit_out,
                        drive: run && (in_slot || !cfg_q.pad_hiz),
                        sync:  sync};

    // Launch on the falling edge so the far end samples on the rising edge
    always_ff @(negedge clk) begin
        if (rst) begin
            line_q <= '{data: 1'b0, drive: 1'b0, sync: cfg_fs_low};
        end else begin
            line_q <= line_nxt;
        end
    end

    assign sd_o  = line_q.data;
    assign sd_oe = line_q.drive;
    assign fs_o  = line_q.sync;

endmodule

// File: tb/tb_aud_frame_tx.sv
module tb_aud_frame_tx;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst;
    logic        cfg_en;
    logic [7:0]  cfg_frame_len;
    logic [6:0]  cfg_fs_width;
    logic        cfg_fs_early;
    logic        cfg_fs_low;
    logic [2:0]  cfg_size;
    logic        cfg_lsb_first;
    logic [3:0]  cfg_slots;
    logic        cfg_pad_hiz;
    logic        s_valid;
    logic [31:0] s_data;
    logic        s_ready;
    logic        sd_o;
    logic        sd_oe;
    logic        fs_o;
    logic        underrun;

    aud_frame_tx dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_frame_len(cfg_frame_len),
        .cfg_fs_width(cfg_fs_width), .cfg_fs_early(cfg_fs_early), .cfg_fs_low(cfg_fs_low),
        .cfg_size(cfg_size), .cfg_lsb_first(cfg_lsb_first), .cfg_slots(cfg_slots),
        .cfg_pad_hiz(cfg_pad_hiz), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .sd_o(sd_o), .sd_oe(sd_oe), .fs_o(fs_o), .underrun(underrun)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string scen = "R11";
    int    valid_mode = 0;

    // Behavioural reference state
    bit          m_run = 1'b0;
    int          m_pos = 0;
    int          m_len = 1, m_act = 1, m_w = 8, m_slots = 1;
    bit          m_early = 1'b0, m_low = 1'b0, m_lsb = 1'b0, m_hiz = 1'b0;
    logic [31:0] m_word = '0;
    bit          m_under = 1'b0;
    bit          have_last = 1'b0;
    logic        last_sd, last_oe, last_fs;

    function automatic int size_of(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 10;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s/%s %s actual=%b expected=%b pos=%0d t=%0t",
                     scen, req, what, act, exp, m_pos, $time);
        end
    endtask

    task automatic setcfg(input int len_m1, input int act_m1, input bit early, input bit low,
                          input int size, input bit lsb, input int slots_m1, input bit hiz);
        cfg_frame_len = 8'(len_m1);
        cfg_fs_width  = 7'(act_m1);
        cfg_fs_early  = early;
        cfg_fs_low    = low;
        cfg_size      = 3'(size);
        cfg_lsb_first = lsb;
        cfg_slots     = 4'(slots_m1);
        cfg_pad_hiz   = hiz;
    endtask

    // Rising-edge update of the model from the inputs of the cycle just ended
    task automatic model_edge(output bit consumed);
        bit start_cyc;
        start_cyc = m_run && ((m_pos % m_w) == 0) && ((m_pos / m_w) < m_slots);
        consumed  = start_cyc && s_valid;
        if (start_cyc) m_word = s_valid ? s_data : 32'h0;
        if (rst || !cfg_en) begin
            m_run = 1'b0;
            m_pos = 0;
            m_under = 1'b0;
        end else begin
            if (start_cyc && !s_valid) m_under = 1'b1;
            if (!m_run || m_pos == m_len - 1) begin
                m_run   = 1'b1;
                m_pos   = 0;
                m_len   = int'(cfg_frame_len) + 1;
                m_act   = int'(cfg_fs_width) + 1;
                m_early = cfg_fs_early;
                m_low   = cfg_fs_low;
                m_w     = size_of(cfg_size);
                m_lsb   = cfg_lsb_first;
                m_slots = int'(cfg_slots) + 1;
                m_hiz   = cfg_pad_hiz;
            end else begin
                m_pos++;
            end
        end
    endtask

    task automatic compare();
        logic        e_sd, e_oe, e_fs, e_rdy;
        logic [31:0] w;
        int          b, look;
        bit          ins;
        string       rq_d, rq_f;
        ins = 1'b0;
        if (!m_run) begin
            e_sd = 1'b0; e_oe = 1'b0; e_fs = cfg_fs_low; e_rdy = 1'b0;
            rq_d = "R11"; rq_f = "R6";
        end else begin
            b     = m_pos % m_w;
            ins   = (m_pos / m_w) < m_slots;
            w     = (b == 0) ? (s_valid ? s_data : 32'h0) : m_word;
            e_rdy = ins && (b == 0);
            if (!ins) e_sd = 1'b0;
            else if (m_lsb) e_sd = w[b];
            else e_sd = w[m_w - 1 - b];
            e_oe  = ins || !m_hiz;
            if (m_early) look = (m_pos == m_len - 1) ? 0 : m_pos + 1;
            else look = m_pos;
            e_fs  = (look < m_act) ^ m_low;
            if (!ins) rq_d = "R8";
            else if (m_lsb) rq_d = "R2";
            else rq_d = "R1";
            if (m_early) rq_f = "R5";
            else rq_f = "R4";
        end
        check(rq_d, "sd_o", sd_o, e_sd);
        check(ins ? "R7" : "R8", "sd_oe", sd_oe, e_oe);
        check(rq_f, "fs_o", fs_o, e_fs);
        check("R9", "s_ready", s_ready, e_rdy);
        check("R9", "underrun", underrun, m_under);
    endtask

    task automatic tick(input int n);
        bit consumed;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge(consumed);
            #1;
            if (consumed) s_data = $urandom;
            if (valid_mode == 1) s_valid = (($urandom % 4) != 0);
            #1;
            if (have_last) begin  // R12: pins hold until the falling edge
                check("R12", "sd_o hold", sd_o, last_sd);
                check("R12", "sd_oe hold", sd_oe, last_oe);
                check("R12", "fs_o hold", fs_o, last_fs);
            end
            #4;
            compare();
            last_sd = sd_o; last_oe = sd_oe; last_fs = fs_o;
            have_last = 1'b1;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_en = 1'b0; s_valid = 1'b1; s_data = $urandom;
        setcfg(7, 0, 0, 0, 0, 0, 0, 0);
        scen = "R11";                    // reset state is idle
        tick(3);
        rst = 1'b0;
        tick(2);

        scen = "R1";                     // 16-bit MSB first, two slots, zero pad
        setcfg(63, 31, 0, 0, 2, 0, 1, 0); cfg_en = 1'b1;
        tick(194);

        scen = "R2";                     // 10-bit LSB first, three slots, floating pad
        setcfg(39, 0, 0, 0, 1, 1, 2, 1);
        tick(82);

        scen = "R5";                     // 20-bit, early active-low FS, four slots
        setcfg(99, 49, 1, 1, 3, 0, 3, 0);
        tick(202);

        scen = "R9";                     // 24-bit LSB first with gaps in the supply
        valid_mode = 1;
        setcfg(47, 7, 0, 0, 4, 1, 1, 0);
        tick(150);
        valid_mode = 0; s_valid = 1'b1;

        scen = "R3";                     // 256-bit frame, 128-bit FS, 16x32 slots cut at the end
        setcfg(255, 127, 1, 0, 5, 0, 15, 1);
        tick(520);

        scen = "R10";                    // change every field in the middle of a frame
        setcfg(29, 3, 0, 0, 0, 0, 2, 0);
        tick(37);
        setcfg(19, 9, 1, 1, 7, 1, 0, 1);
        tick(80);

        scen = "R6";                     // one-bit frames, FS held active low
        setcfg(0, 0, 1, 1, 0, 0, 0, 0);
        tick(10);

        scen = "R11";                    // stop, idle FS level follows polarity, restart mid-run
        cfg_en = 1'b0; cfg_fs_low = 1'b1;
        tick(4);
        cfg_fs_low = 1'b0;
        tick(3);
        setcfg(23, 2, 0, 0, 0, 0, 1, 0);
        cfg_en = 1'b1;
        tick(13);
        s_valid = 1'b0;                  // R9: flag set, then cleared by disable
        tick(20);
        cfg_en = 1'b0;
        tick(3);
        s_valid = 1'b1; cfg_en = 1'b1;
        tick(30);
        rst = 1'b1;                      // reset while running
        tick(2);
        rst = 1'b0;
        tick(10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule